// File: doc/BRIEF.md
# Pipeline Hazard and Forwarding Control

This block is the hazard controller for an in-order integer pipeline with five stages (fetch, decode, execute, memory, write-back). Each cycle it looks at the register fields, write enables and load flags held in the four stage latches. From these it computes the operand bypass selects for the execute stage and a stall that freezes the program counter and the fetch/decode latch. While stalled, the datapath injects a bubble into the decode/execute latch. Operands are read in decode and results are written in write-back, so only read-after-write dependences need handling.

Conditional branches are resolved in decode. The block picks the most recent copy of the tested register, runs a zero test, and presents the redirect target, which is the branch address plus its offset. The single instruction after a branch always enters the pipeline. When the cancelling variant is built in, the branch can carry a prediction hint. The block then flags the slot instruction so that its write-back and store are suppressed when the hint turns out wrong. All outputs are combinational in the latch contents and are forced quiet while reset is held.

Top module: `hazard_ctl`

## Requirements
- R1: While rst_n is low, stall, redirect and annul_slot are 0 and both bypass selects are 00, whatever the latch inputs.
- R2: Bypass select encoding is 00 register file, 01 memory/write-back latch, 10 execute/memory latch. When an execute-stage source matches a non-load writer in the execute/memory latch, the select is 10, even if the memory/write-back latch matches too.
- R3: When an execute-stage source matches only a writer in the memory/write-back latch, the select is 01.
- R4: Register 0 is never bypassed, never causes a stall and always tests as zero in a branch, regardless of latch contents or the register file value.
- R5: A load in the decode/execute latch whose destination matches a source actually used by the decode-stage instruction raises stall for that cycle. Once the bubble is in place, the value reaches execute through select 01.
- R6: No stall is raised when the matching load writes nothing, when the matching source is unused, or when the load is already in the memory stage and the decode instruction is not a branch.
- R7: Branch kind encoding is 00 none, 01 taken-if-zero, 10 taken-if-nonzero. A resolved taken branch raises redirect with redirect_pc equal to ifid_pc plus ifid_offset; a not-taken branch leaves redirect low.
- R8: The branch test uses the execute/memory result when that latch holds a non-load writer of the tested register, otherwise the memory/write-back result when it matches, otherwise the register file value.
- R9: A branch whose tested register is written by the instruction in execute, or by a load in memory, raises stall, and neither redirect nor annul_slot is raised in that cycle.
- R10: Hint encoding is 00 none, 01 likely taken, 10 likely not taken. annul_slot is raised on resolution exactly when a hinted branch goes against its hint, and never for hint 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (used for property sampling) |
| rst_n | input | 1 | Active-low reset; silences all controls |
| ifid_rs1 | input | RAW | First source of the decode-stage instruction (also the branch test register) |
| ifid_rs2 | input | RAW | Second source of the decode-stage instruction |
| ifid_use_rs1 | input | 1 | Decode instruction reads its first source |
| ifid_use_rs2 | input | 1 | Decode instruction reads its second source |
| ifid_br_kind | input | 2 | Branch kind of the decode instruction |
| ifid_br_hint | input | 2 | Prediction hint for the cancelling variant |
| ifid_pc | input | XLEN | Address of the decode-stage instruction |
| ifid_offset | input | XLEN | Sign-extended branch offset |
| ifid_rs1_val | input | XLEN | Register file value of the tested register |
| idex_rs1 | input | RAW | First source of the execute-stage instruction |
| idex_rs2 | input | RAW | Second source of the execute-stage instruction |
| idex_rd | input | RAW | Destination in the execute stage |
| idex_wen | input | 1 | Execute-stage instruction writes a register |
| idex_load | input | 1 | Execute-stage instruction is a load |
| exmem_rd | input | RAW | Destination in the memory stage |
| exmem_wen | input | 1 | Memory-stage instruction writes a register |
| exmem_load | input | 1 | Memory-stage instruction is a load |
| exmem_result | input | XLEN | ALU result held in the execute/memory latch |
| memwb_rd | input | RAW | Destination in the write-back stage |
| memwb_wen | input | 1 | Write-back instruction writes a register |
| memwb_result | input | XLEN | Value about to be written back |
| fwd_a | output | 2 | Bypass select for the first ALU operand |
| fwd_b | output | 2 | Bypass select for the second ALU operand |
| stall | output | 1 | Hold PC and fetch/decode latch, bubble decode/execute |
| redirect | output | 1 | Resolved taken branch |
| redirect_pc | output | XLEN | Branch target |
| annul_slot | output | 1 | Suppress write-back and store of the delay-slot instruction |

## Verification
The properties take for granted that the latches come from a legal pipeline. In particular, a load never sits in the execute/memory latch while a consumer of its destination is in execute, because the load-use stall has already inserted a bubble. Under that assumption, the property that a select of 10 points at a non-load writer follows from the inputs alone. The stimulus table and the directed load-use sequence only build latch states a correctly stalled pipeline can reach. The execute stage holds a bubble after every stall, and a memory-stage load always has register 0 or an unrelated register in the execute source fields.

// File: rtl/hz_pkg.sv
package hz_pkg;

    typedef enum logic [1:0] {
        FWD_RF    = 2'b00,
        FWD_MEMWB = 2'b01,
        FWD_EXMEM = 2'b10
    } fwd_sel_e;

    typedef enum logic [1:0] {
        BR_NONE = 2'b00,
        BR_EQZ  = 2'b01,
        BR_NEZ  = 2'b10
    } br_kind_e;

    typedef enum logic [1:0] {
        HINT_NONE      = 2'b00,
        HINT_TAKEN     = 2'b01,
        HINT_NOT_TAKEN = 2'b10
    } br_hint_e;

endpackage

// File: rtl/hz_fwd_unit.sv
module hz_fwd_unit
    import hz_pkg::*;
#(
    parameter int RAW = 5
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [RAW-1:0] src,
    input  logic [RAW-1:0] exmem_rd,
    input  logic           exmem_wen,
    input  logic           exmem_load,
    input  logic [RAW-1:0] memwb_rd,
    input  logic           memwb_wen,
    output logic [1:0]     sel
);

    fwd_sel_e sel_d;
    logic     src_live_d;
    logic     hit_exmem_d;
    logic     hit_memwb_d;

    always_comb begin
        src_live_d  = (src != '0);
        hit_exmem_d = src_live_d && exmem_wen && !exmem_load && (exmem_rd == src);
        hit_memwb_d = src_live_d && memwb_wen && (memwb_rd == src);
        sel_d       = FWD_RF;
        if (hit_exmem_d) begin
            sel_d = FWD_EXMEM;
        end else if (hit_memwb_d) begin
            sel_d = FWD_MEMWB;
        end
    end

    assign sel = sel_d;

    // R2
    fwd_exmem_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == FWD_EXMEM) |-> (exmem_wen && !exmem_load && exmem_rd == src));

    // R4
    fwd_zero_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (src == '0) |-> (sel == FWD_RF));

endmodule

// File: rtl/hz_stall_unit.sv
module hz_stall_unit
    import hz_pkg::*;
#(
    parameter int RAW = 5
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [RAW-1:0] rs1,
    input  logic [RAW-1:0] rs2,
    input  logic           use_rs1,
    input  logic           use_rs2,
    input  logic [1:0]     br_kind,
    input  logic [RAW-1:0] idex_rd,
    input  logic           idex_wen,
    input  logic           idex_load,
    input  logic [RAW-1:0] exmem_rd,
    input  logic           exmem_wen,
    input  logic           exmem_load,
    output logic           stall
);

    logic load_hit_d;
    logic br_hit_d;
    logic is_branch_d;

    always_comb begin
        is_branch_d = (br_kind != BR_NONE);
        load_hit_d  = idex_load && idex_wen && (idex_rd != '0) &&
                      ((use_rs1 && idex_rd == rs1) || (use_rs2 && idex_rd == rs2));
        br_hit_d    = is_branch_d && (rs1 != '0) &&
                      ((idex_wen && idex_rd == rs1) ||
                       (exmem_load && exmem_wen && exmem_rd == rs1));
    end

    assign stall = load_hit_d || br_hit_d;

    // R4
    stall_zero_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rs1 == '0 && rs2 == '0) |-> !stall);

    // R6
    stall_no_writer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!idex_wen && br_kind == BR_NONE) |-> !stall);

endmodule

// File: rtl/hz_branch_unit.sv
module hz_branch_unit
    import hz_pkg::*;
#(
    parameter int XLEN      = 32,
    parameter int RAW       = 5,
    parameter bit CANCEL_EN = 1'b1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [RAW-1:0]  rs1,
    input  logic [1:0]      br_kind,
    input  logic [1:0]      br_hint,
    input  logic [XLEN-1:0] pc,
    input  logic [XLEN-1:0] offset,
    input  logic [XLEN-1:0] rf_val,
    input  logic [RAW-1:0]  exmem_rd,
    input  logic            exmem_wen,
    input  logic            exmem_load,
    input  logic [XLEN-1:0] exmem_val,
    input  logic [RAW-1:0]  memwb_rd,
    input  logic            memwb_wen,
    input  logic [XLEN-1:0] memwb_val,
    input  logic            hold,
    output logic            redirect,
    output logic [XLEN-1:0] target,
    output logic            annul
);

    logic [XLEN-1:0] opnd_d;
    logic            taken_d;
    logic            resolve_d;
    logic            miss_hint_d;

    always_comb begin
        if (rs1 == '0) begin
            opnd_d = '0;
        end else if (exmem_wen && !exmem_load && exmem_rd == rs1) begin
            opnd_d = exmem_val;
        end else if (memwb_wen && memwb_rd == rs1) begin
            opnd_d = memwb_val;
        end else begin
            opnd_d = rf_val;
        end

        case (br_kind)
            BR_EQZ:  taken_d = (opnd_d == '0);
            BR_NEZ:  taken_d = (opnd_d != '0);
            default: taken_d = 1'b0;
        endcase

        resolve_d   = (br_kind != BR_NONE) && !hold;
        miss_hint_d = ((br_hint == HINT_TAKEN)     && !taken_d) ||
                      ((br_hint == HINT_NOT_TAKEN) &&  taken_d);
    end

    assign redirect = resolve_d && taken_d;
    assign target   = pc + offset;

    generate
        if (CANCEL_EN) begin : g_cancel
            assign annul = resolve_d && miss_hint_d;
        end else begin : g_plain
            assign annul = 1'b0;
        end
    endgenerate

    // R9
    br_hold_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold |-> (!redirect && !annul));

    // R10
    annul_needs_hint_chk: assert property (@(posedge clk) disable iff (!rst_n)
        annul |-> (br_hint != HINT_NONE && br_kind != BR_NONE));

    // R7
    redirect_needs_branch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |-> (br_kind != BR_NONE));

endmodule

// File: rtl/hazard_ctl.sv
module hazard_ctl
    import hz_pkg::*;
#(
    parameter int XLEN      = 32,
    parameter int RAW       = 5,
    parameter bit CANCEL_EN = 1'b1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [RAW-1:0]  ifid_rs1,
    input  logic [RAW-1:0]  ifid_rs2,
    input  logic            ifid_use_rs1,
    input  logic            ifid_use_rs2,
    input  logic [1:0]      ifid_br_kind,
    input  logic [1:0]      ifid_br_hint,
    input  logic [XLEN-1:0] ifid_pc,
    input  logic [XLEN-1:0] ifid_offset,
    input  logic [XLEN-1:0] ifid_rs1_val,
    input  logic [RAW-1:0]  idex_rs1,
    input  logic [RAW-1:0]  idex_rs2,
    input  logic [RAW-1:0]  idex_rd,
    input  logic            idex_wen,
    input  logic            idex_load,
    input  logic [RAW-1:0]  exmem_rd,
    input  logic            exmem_wen,
    input  logic            exmem_load,
    input  logic [XLEN-1:0] exmem_result,
    input  logic [RAW-1:0]  memwb_rd,
    input  logic            memwb_wen,
    input  logic [XLEN-1:0] memwb_result,
    output logic [1:0]      fwd_a,
    output logic [1:0]      fwd_b,
    output logic            stall,
    output logic            redirect,
    output logic [XLEN-1:0] redirect_pc,
    output logic            annul_slot
);

    localparam int N_OPND = 2;

    logic [N_OPND-1:0][RAW-1:0] ex_src;
    logic [N_OPND-1:0][1:0]     sel_raw;
    logic                       stall_raw;
    logic                       redirect_raw;
    logic                       annul_raw;

    assign ex_src[0] = idex_rs1;
    assign ex_src[1] = idex_rs2;

    generate
        for (genvar gi = 0; gi < N_OPND; gi++) begin : g_opnd
            hz_fwd_unit #(.RAW(RAW)) u_fwd (
                .clk        (clk),
                .rst_n      (rst_n),
                .src        (ex_src[gi]),
                .exmem_rd   (exmem_rd),
                .exmem_wen  (exmem_wen),
                .exmem_load (exmem_load),
                .memwb_rd   (memwb_rd),
                .memwb_wen  (memwb_wen),
                .sel        (sel_raw[gi])
            );
        end
    endgenerate

    hz_stall_unit #(.RAW(RAW)) u_stall (
        .clk        (clk),
        .rst_n      (rst_n),
        .rs1        (ifid_rs1),
        .rs2        (ifid_rs2),
        .use_rs1    (ifid_use_rs1),
        .use_rs2    (ifid_use_rs2),
        .br_kind    (ifid_br_kind),
        .idex_rd    (idex_rd),
        .idex_wen   (idex_wen),
        .idex_load  (idex_load),
        .exmem_rd   (exmem_rd),
        .exmem_wen  (exmem_wen),
        .exmem_load (exmem_load),
        .stall      (stall_raw)
    );

    hz_branch_unit #(.XLEN(XLEN), .RAW(RAW), .CANCEL_EN(CANCEL_EN)) u_branch (
        .clk        (clk),
        .rst_n      (rst_n),
        .rs1        (ifid_rs1),
        .br_kind    (ifid_br_kind),
        .br_hint    (ifid_br_hint),
        .pc         (ifid_pc),
        .offset     (ifid_offset),
        .rf_val     (ifid_rs1_val),
        .exmem_rd   (exmem_rd),
        .exmem_wen  (exmem_wen),
        .exmem_load (exmem_load),
        .exmem_val  (exmem_result),
        .memwb_rd   (memwb_rd),
        .memwb_wen  (memwb_wen),
        .memwb_val  (memwb_result),
        .hold       (stall_raw),
        .redirect   (redirect_raw),
        .target     (redirect_pc),
        .annul      (annul_raw)
    );

    assign fwd_a      = rst_n ? sel_raw[0] : FWD_RF;
    assign fwd_b      = rst_n ? sel_raw[1] : FWD_RF;
    assign stall      = rst_n && stall_raw;
    assign redirect   = rst_n && redirect_raw;
    assign annul_slot = rst_n && annul_raw;

    // R1
    rst_quiet_chk: assert property (@(posedge clk)
        !rst_n |-> (!stall && !redirect && !annul_slot && fwd_a == 2'b00 && fwd_b == 2'b00));

    // R9
    stall_blocks_redirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> !redirect);

endmodule

// File: tb/hazard_ctl_tb.sv
`timescale 1ns/1ps
module hazard_ctl_tb;

    typedef struct packed {
        logic [4:0] rs1;  logic [4:0] rs2;  logic u1; logic u2;
        logic [1:0] br;   logic [1:0] hint;
        logic [4:0] xrs1; logic [4:0] xrs2; logic [4:0] xrd; logic xw; logic xl;
        logic [4:0] mrd;  logic mw; logic ml;
        logic [4:0] wrd;  logic ww;
        logic [7:0] rfv;  logic [7:0] mv;  logic [7:0] wv;
    } stim_t;

    typedef struct packed {
        logic [1:0] fa; logic [1:0] fb; logic st; logic rd; logic an;
    } exp_t;

    localparam int NV = 18;
    localparam logic [31:0] PC_C  = 32'h0000_0100;
    localparam logic [31:0] OFF_C = 32'h0000_0040;

    localparam stim_t VEC [NV] = '{
        '{5'd0,5'd0,1'b0,1'b0,2'd0,2'd0, 5'd0,5'd0,5'd0,1'b0,1'b0, 5'd0,1'b0,1'b0, 5'd0,1'b0, 8'd0,8'd0,8'd0},
        '{5'd0,5'd0,1'b0,1'b0,2'd0,2'd0, 5'd3,5'd0,5'd0,1'b0,1'b0, 5'd3,1'b1,1'b0, 5'd0,1'b0, 8'd0,8'd0,8'd0},
        '{5'd0,5'd0,1'b0,1'b0,2'd0,2'd0, 5'd0,5'd4,5'd0,1'b0,1'b0, 5'd0,1'b0,1'b0, 5'd4,1'b1, 8'd0,8'd0,8'd0},
        '{5'd0,5'd0,1'b0,1'b0,2'd0,2'd0, 5'd5,5'd5,5'd0,1'b0,1'b0, 5'd5,1'b1,1'b0, 5'd5,1'b1, 8'd0,8'd0,8'd0},
        '{5'd0,5'd0,1'b1,1'b1,2'd0,2'd0, 5'd0,5'd0,5'd0,1'b1,1'b1, 5'd0,1'b1,1'b0, 5'd0,1'b1, 8'd0,8'd0,8'd0},
        '{5'd1,5'd7,1'b1,1'b1,2'd0,2'd0, 5'd0,5'd0,5'd7,1'b1,1'b1, 5'd0,1'b0,1'b0, 5'd0,1'b0, 8'd0,8'd0,8'd0},
        '{5'd1,5'd7,1'b1,1'b0,2'd0,2'd0, 5'd0,5'd0,5'd7,1'b1,1'b1, 5'd0,1'b0,1'b0, 5'd0,1'b0, 8'd0,8'd0,8'd0},
        '{5'd7,5'd0,1'b1,1'b0,2'd0,2'd0, 5'd0,5'd0,5'd0,1'b0,1'b0, 5'd7,1'b1,1'b1, 5'd0,1'b0, 8'd0,8'd0,8'd0},
        '{5'd2,5'd0,1'b1,1'b0,2'd1,2'd0, 5'd0,5'd0,5'd0,1'b0,1'b0, 5'd0,1'b0,1'b0, 5'd0,1'b0, 8'd0,8'd0,8'd0},
        '{5'd2,5'd0,1'b1,1'b0,2'd2,2'd0, 5'd0,5'd0,5'd0,1'b0,1'b0, 5'd0,1'b0,1'b0, 5'd0,1'b0, 8'd5,8'd0,8'd0},
        '{5'd2,5'd0,1'b1,1'b0,2'd1,2'd0, 5'd0,5'd0,5'd0,1'b0,1'b0, 5'd2,1'b1,1'b0, 5'd2,1'b1, 8'd0,8'd9,8'd0},
        '{5'd2,5'd0,1'b1,1'b0,2'd2,2'd0, 5'd0,5'd0,5'd0,1'b0,1'b0, 5'd0,1'b0,1'b0, 5'd2,1'b1, 8'd0,8'd0,8'd1},
        '{5'd2,5'd0,1'b1,1'b0,2'd1,2'd0, 5'd0,5'd0,5'd2,1'b1,1'b0, 5'd0,1'b0,1'b0, 5'd0,1'b0, 8'd0,8'd0,8'd0},
        '{5'd2,5'd0,1'b1,1'b0,2'd1,2'd1, 5'd0,5'd0,5'd0,1'b0,1'b0, 5'd2,1'b1,1'b1, 5'd0,1'b0, 8'd0,8'd0,8'd0},
        '{5'd2,5'd0,1'b1,1'b0,2'd1,2'd1, 5'd0,5'd0,5'd0,1'b0,1'b0, 5'd0,1'b0,1'b0, 5'd0,1'b0, 8'd3,8'd0,8'd0},
        '{5'd2,5'd0,1'b1,1'b0,2'd2,2'd2, 5'd0,5'd0,5'd0,1'b0,1'b0, 5'd0,1'b0,1'b0, 5'd0,1'b0, 8'd3,8'd0,8'd0},
        '{5'd2,5'd0,1'b1,1'b0,2'd2,2'd1, 5'd0,5'd0,5'd0,1'b0,1'b0, 5'd0,1'b0,1'b0, 5'd0,1'b0, 8'd3,8'd0,8'd0},
        '{5'd0,5'd0,1'b1,1'b0,2'd1,2'd0, 5'd0,5'd0,5'd0,1'b1,1'b0, 5'd0,1'b1,1'b1, 5'd0,1'b1, 8'd5,8'd0,8'd0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  ifid_rs1 = '0, ifid_rs2 = '0;
    logic        ifid_use_rs1 = 1'b0, ifid_use_rs2 = 1'b0;
    logic [1:0]  ifid_br_kind = '0, ifid_br_hint = '0;
    logic [31:0] ifid_pc = PC_C, ifid_offset = OFF_C, ifid_rs1_val = '0;
    logic [4:0]  idex_rs1 = '0, idex_rs2 = '0, idex_rd = '0;
    logic        idex_wen = 1'b0, idex_load = 1'b0;
    logic [4:0]  exmem_rd = '0;
    logic        exmem_wen = 1'b0, exmem_load = 1'b0;
    logic [31:0] exmem_result = '0;
    logic [4:0]  memwb_rd = '0;
    logic        memwb_wen = 1'b0;
    logic [31:0] memwb_result = '0;
    logic [1:0]  fwd_a, fwd_b;
    logic        stall, redirect, annul_slot;
    logic [31:0] redirect_pc;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    hazard_ctl u_dut (
        .clk(clk), .rst_n(rst_n),
        .ifid_rs1(ifid_rs1), .ifid_rs2(ifid_rs2),
        .ifid_use_rs1(ifid_use_rs1), .ifid_use_rs2(ifid_use_rs2),
        .ifid_br_kind(ifid_br_kind), .ifid_br_hint(ifid_br_hint),
        .ifid_pc(ifid_pc), .ifid_offset(ifid_offset), .ifid_rs1_val(ifid_rs1_val),
        .idex_rs1(idex_rs1), .idex_rs2(idex_rs2), .idex_rd(idex_rd),
        .idex_wen(idex_wen), .idex_load(idex_load),
        .exmem_rd(exmem_rd), .exmem_wen(exmem_wen), .exmem_load(exmem_load),
        .exmem_result(exmem_result),
        .memwb_rd(memwb_rd), .memwb_wen(memwb_wen), .memwb_result(memwb_result),
        .fwd_a(fwd_a), .fwd_b(fwd_b), .stall(stall), .redirect(redirect),
        .redirect_pc(redirect_pc), .annul_slot(annul_slot)
    );

    // Reference model written from the requirements
    function automatic exp_t model(stim_t s);
        exp_t e;
        logic [7:0] v;
        logic tk;
        e.fa = 2'b00;
        if (s.xrs1 != 0 && s.mw && !s.ml && s.mrd == s.xrs1)      e.fa = 2'b10;
        else if (s.xrs1 != 0 && s.ww && s.wrd == s.xrs1)          e.fa = 2'b01;
        e.fb = 2'b00;
        if (s.xrs2 != 0 && s.mw && !s.ml && s.mrd == s.xrs2)      e.fb = 2'b10;
        else if (s.xrs2 != 0 && s.ww && s.wrd == s.xrs2)          e.fb = 2'b01;
        e.st = (s.xl && s.xw && s.xrd != 0 &&
                ((s.u1 && s.xrd == s.rs1) || (s.u2 && s.xrd == s.rs2))) ||
               (s.br != 2'd0 && s.rs1 != 0 &&
                ((s.xw && s.xrd == s.rs1) || (s.ml && s.mw && s.mrd == s.rs1)));
        if (s.rs1 == 0)                               v = 8'd0;
        else if (s.mw && !s.ml && s.mrd == s.rs1)     v = s.mv;
        else if (s.ww && s.wrd == s.rs1)              v = s.wv;
        else                                          v = s.rfv;
        tk = (s.br == 2'd1) ? (v == 0) : (s.br == 2'd2) ? (v != 0) : 1'b0;
        e.rd = !e.st && tk;
        e.an = !e.st && s.br != 2'd0 &&
               ((s.hint == 2'd1 && !tk) || (s.hint == 2'd2 && tk));
        return e;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic apply(input stim_t s);
        @(negedge clk);
        ifid_rs1 = s.rs1; ifid_rs2 = s.rs2; ifid_use_rs1 = s.u1; ifid_use_rs2 = s.u2;
        ifid_br_kind = s.br; ifid_br_hint = s.hint; ifid_rs1_val = {24'd0, s.rfv};
        idex_rs1 = s.xrs1; idex_rs2 = s.xrs2; idex_rd = s.xrd; idex_wen = s.xw; idex_load = s.xl;
        exmem_rd = s.mrd; exmem_wen = s.mw; exmem_load = s.ml; exmem_result = {24'd0, s.mv};
        memwb_rd = s.wrd; memwb_wen = s.ww; memwb_result = {24'd0, s.wv};
        #1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R1: reset holds everything quiet even with hazardous latches
        apply(VEC[5]);
        check("R1 stall in reset", {31'd0, stall}, 32'd0);
        apply(VEC[8]);
        check("R1 redirect in reset", {31'd0, redirect}, 32'd0);
        apply(VEC[3]);
        check("R1 fwd_a in reset", {30'd0, fwd_a}, 32'd0);
        check("R1 fwd_b in reset", {30'd0, fwd_b}, 32'd0);
        apply(VEC[14]);
        check("R1 annul in reset", {31'd0, annul_slot}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // Table walk against the reference model
        for (int i = 0; i < NV; i++) begin
            exp_t e;
            apply(VEC[i]);
            e = model(VEC[i]);
            check($sformatf("R2 R3 R4 fwd_a row %0d", i), {30'd0, fwd_a}, {30'd0, e.fa});
            check($sformatf("R2 R3 R4 fwd_b row %0d", i), {30'd0, fwd_b}, {30'd0, e.fb});
            check($sformatf("R5 R6 R9 stall row %0d", i), {31'd0, stall}, {31'd0, e.st});
            check($sformatf("R7 R8 redirect row %0d", i), {31'd0, redirect}, {31'd0, e.rd});
            check($sformatf("R10 annul row %0d", i), {31'd0, annul_slot}, {31'd0, e.an});
            if (e.rd) check($sformatf("R7 target row %0d", i), redirect_pc, PC_C + OFF_C);
        end

        // Directed constants for key corners
        apply(VEC[3]);
        check("R2 priority to younger result", {30'd0, fwd_a}, 32'd2);
        apply(VEC[4]);
        check("R4 zero register not bypassed", {30'd0, fwd_b}, 32'd0);
        apply(VEC[17]);
        check("R4 zero register tests as zero", {31'd0, redirect}, 32'd1);
        apply(VEC[10]);
        check("R8 execute/memory value wins", {31'd0, redirect}, 32'd0);
        apply(VEC[13]);
        check("R9 load in memory delays branch", {31'd0, stall}, 32'd1);
        apply(VEC[15]);
        check("R10 likely-not-taken taken annuls", {31'd0, annul_slot}, 32'd1);
        apply(VEC[16]);
        check("R10 hint met no annul", {31'd0, annul_slot}, 32'd0);

        // R5: load-use sequence across three cycles
        apply('{5'd6,5'd0,1'b1,1'b0,2'd0,2'd0, 5'd0,5'd0,5'd6,1'b1,1'b1,
                5'd0,1'b0,1'b0, 5'd0,1'b0, 8'd0,8'd0,8'd0});
        check("R5 load-use stalls", {31'd0, stall}, 32'd1);
        apply('{5'd6,5'd0,1'b1,1'b0,2'd0,2'd0, 5'd0,5'd0,5'd0,1'b0,1'b0,
                5'd6,1'b1,1'b1, 5'd0,1'b0, 8'd0,8'd0,8'd0});
        check("R5 R6 bubble cycle no stall", {31'd0, stall}, 32'd0);
        check("R5 bubble cycle no bypass", {30'd0, fwd_a}, 32'd0);
        apply('{5'd0,5'd0,1'b0,1'b0,2'd0,2'd0, 5'd6,5'd0,5'd0,1'b1,1'b0,
                5'd0,1'b0,1'b0, 5'd6,1'b1, 8'd0,8'd0,8'd0});
        check("R5 R3 loaded value from write-back latch", {30'd0, fwd_a}, 32'd1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule